// File: doc/BRIEF.md
# Constant-Weight Pseudo-Exhaustive Pattern Generator

This block drives the test-signal inputs of a combinational circuit under self-test with a pseudo-exhaustive vector set. The circuit is described by two elaboration parameters: `P`, the number of test signals, and `W`, the largest number of those signals that any single output depends on. Every W-wide slice of the emitted set then takes all 2^W values, which exercises each output cone exhaustively with far fewer than 2^P vectors.

The set depends on how `P` relates to `W`. With `P == W` every P-bit pattern is produced. With `P == W + 1` only the patterns of one parity class are produced. With `P > W + 1` the set is a union of whole constant-weight classes, and a weight mask parameter chooses which classes. All three cases are handled as one walk over weight classes. Classes are visited from the lowest weight to the highest, and inside a class the vectors fall in binary value.

A synchronous start pulse arms the walk. After that, every clock cycle with `enable_i` high puts out one vector with a valid strobe. A one-cycle done pulse follows the final vector.

Top module: `cwpe_gen`

## Requirements
- R1: After reset, `vec_o` is all zeros and `valid_o` and `done_o` are low until a start pulse is followed by an enabled cycle.
- R2: With `P == W`, one run emits each of the 2^P patterns exactly once (P=3: 8 vectors).
- R3: With `P == W + 1`, one run emits exactly the 2^(P-1) patterns of the selected parity, each once. `EVEN_PARITY = 0` (the default) selects an odd count of ones and `EVEN_PARITY = 1` selects an even count. For P=4, W=3 with odd parity the set is the four weight-1 and the four weight-3 vectors.
- R4: With `P > W + 1`, one run emits, each once, every P-bit pattern whose count of ones k has bit k of `WEIGHT_MASK` set, and no other pattern. The default P=5, W=2, `WEIGHT_MASK` bits 1 and 3 gives 15 vectors.
- R5: Weight classes are emitted in ascending weight. Within a class, vectors are emitted in strictly descending unsigned binary value, starting at the value with the top k bits set.
- R6: While a run is active, each rising edge with `enable_i` high emits the next vector with `valid_o` high in the following cycle. An edge with `enable_i` low leaves `valid_o` low in the following cycle and `vec_o` unchanged.
- R7: `done_o` is high for exactly one cycle, the cycle right after the final valid vector. In that cycle `valid_o` is low, and `vec_o` keeps the final vector until the next vector is emitted.
- R8: A `start_i` pulse at any time, including mid-run, abandons the current walk and restarts from the first vector. It takes priority over `enable_i`, and it clears `valid_o` and `done_o` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous pulse that arms a new run from the first vector |
| enable_i | input | 1 | Advance one vector on this edge |
| vec_o | output | P | Current test vector |
| valid_o | output | 1 | `vec_o` carries a freshly emitted vector |
| done_o | output | 1 | One-cycle pulse after the final vector |

## Verification
Four parameter sets are run side by side, and each one exercises a different branch of the set selection.

- **P=3, W=3**: the full space, which checks that nothing is dropped.
- **P=4, W=3, odd and even parity**: two mirror-image halves. A parity mix-up shows up here as a wrong set rather than a wrong count.
- **P=5, W=2 with a sparse weight mask**: a set that skips weights 0, 2, 4 and 5, so a mask or weight-stepping fault shows up as stray or missing vectors.

Each run is compared in order against a list that the bench builds by brute-force enumeration. Duplicates are tracked separately. Runs are repeated with an enable gap and with a mid-run restart, which separate the hold behaviour and the restart priority from the stepping logic.

// File: rtl/cwpe_pkg.sv
package cwpe_pkg;
  localparam int MAX_P = 32;
  typedef logic [MAX_P:0] wmask_t;

  function automatic int popcnt(logic [MAX_P-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < MAX_P; i++) n += int'(v[i]);
    return n;
  endfunction

  // Weight classes to emit, chosen by the p/w relation
  function automatic wmask_t class_mask(int p, int w, bit even_par, wmask_t user);
    wmask_t m;
    m = '0;
    for (int k = 0; k <= MAX_P; k++) begin
      if (k <= p) begin
        if (p == w)          m[k] = 1'b1;
        else if (p == w + 1) m[k] = ((k % 2) == (even_par ? 0 : 1));
        else                 m[k] = user[k];
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/cwpe_weight_seq.sv
module cwpe_weight_seq #(
  parameter int          P    = 5,
  parameter logic [P:0]  MASK = '1,
  localparam int         WB   = $clog2(P + 2)
) (
  input  logic [WB-1:0] cur_w_i,
  output logic [WB-1:0] first_w_o,
  output logic          first_ok_o,
  output logic [WB-1:0] next_w_o,
  output logic          next_ok_o
);
  always_comb begin
    first_w_o  = '0;
    first_ok_o = 1'b0;
    next_w_o   = '0;
    next_ok_o  = 1'b0;
    for (int k = P; k >= 0; k--) begin
      if (MASK[k]) begin
        first_w_o  = WB'(k);
        first_ok_o = 1'b1;
        if (WB'(k) > cur_w_i) begin
          next_w_o  = WB'(k);
          next_ok_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cwpe_comb_step.sv
module cwpe_comb_step #(
  parameter int P  = 5,
  localparam int SW = $clog2(P) + 1
) (
  input  logic [P-1:0] vec_i,
  output logic [P-1:0] prev_o,
  output logic         last_o
);
  logic [P-1:0] inv, low, sum, nxt;
  logic [SW-1:0] tz;

  // lowest member of a class is 0..01..1
  assign last_o = ((vec_i + P'(1)) & vec_i) == '0;

  // next smaller value of equal weight = complement of next larger of complement
  assign inv = ~vec_i;
  assign low = inv & (~inv + P'(1));
  assign sum = inv + low;

  always_comb begin
    tz = '0;
    for (int i = P - 1; i >= 0; i--) if (inv[i]) tz = SW'(i);
  end

  assign nxt    = sum | (((sum ^ inv) >> 2) >> tz);
  assign prev_o = ~nxt;
endmodule

// File: rtl/cwpe_gen.sv
module cwpe_gen #(
  parameter int              P           = 5,
  parameter int              W           = 2,
  parameter bit              EVEN_PARITY = 1'b0,
  parameter cwpe_pkg::wmask_t WEIGHT_MASK = 33'h0000_000A
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         enable_i,
  output logic [P-1:0] vec_o,
  output logic         valid_o,
  output logic         done_o
);
  import cwpe_pkg::*;

  localparam int         WB       = $clog2(P + 2);
  localparam wmask_t     FULL_MSK = class_mask(P, W, EVEN_PARITY, WEIGHT_MASK);
  localparam logic [P:0] EMASK    = FULL_MSK[P:0];

  initial begin
    if (P < 1 || P > MAX_P || W < 1 || W > P)
      $error("cwpe_gen: bad P/W");
  end

  logic          run_q, pend_q;
  logic [WB-1:0] cur_w_q;
  logic [P-1:0]  nxt_q;

  logic [WB-1:0] first_w, next_w;
  logic          first_ok, next_ok;
  logic [P-1:0]  prev_v;
  logic          last_in_class;

  cwpe_weight_seq #(.P(P), .MASK(EMASK)) u_wseq (
    .cur_w_i   (cur_w_q),
    .first_w_o (first_w),
    .first_ok_o(first_ok),
    .next_w_o  (next_w),
    .next_ok_o (next_ok)
  );

  cwpe_comb_step #(.P(P)) u_step (
    .vec_i (nxt_q),
    .prev_o(prev_v),
    .last_o(last_in_class)
  );

  // highest value of weight k: top k bits set
  function automatic logic [P-1:0] top_of(logic [WB-1:0] k);
    logic [P-1:0] f;
    f = '0;
    for (int i = 0; i < P; i++) if (i >= P - int'(k)) f[i] = 1'b1;
    return f;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      cur_w_q <= '0;
      nxt_q   <= '0;
      vec_o   <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      run_q   <= first_ok;
      pend_q  <= !first_ok;
      cur_w_q <= first_w;
      nxt_q   <= top_of(first_w);
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o  <= pend_q;
      pend_q  <= 1'b0;
      valid_o <= 1'b0;
      if (run_q && enable_i) begin
        vec_o   <= nxt_q;
        valid_o <= 1'b1;
        if (!last_in_class) begin
          nxt_q <= prev_v;
        end else if (next_ok) begin
          cur_w_q <= next_w;
          nxt_q   <= top_of(next_w);
        end else begin
          run_q  <= 1'b0;
          pend_q <= 1'b1;
        end
      end
    end
  end

  function automatic int wt(logic [P-1:0] v);
    return popcnt(MAX_P'(v));
  endfunction

  // R7
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  idle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !valid_o);
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(vec_o));
  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o && !done_o);
  // R4
  class_member_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> EMASK[wt(vec_o)]);
  // R5
  desc_in_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && (wt(vec_o) == wt($past(vec_o))) |-> vec_o < $past(vec_o));
  // R5
  asc_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && (wt(vec_o) != wt($past(vec_o))) |-> wt(vec_o) > wt($past(vec_o)));
endmodule

// File: tb/cwpe_gen_tb.sv
module cwpe_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic enable = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [4:0] v0; logic [2:0] v1; logic [3:0] v2, v3;
  logic [7:0] vw [4];
  logic       vld [4];
  logic       dn  [4];

  cwpe_gen u_dut (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .enable_i(enable),
                  .vec_o(v0), .valid_o(vld[0]), .done_o(dn[0]));
  cwpe_gen #(.P(3), .W(3)) u_all (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
                  .enable_i(enable), .vec_o(v1), .valid_o(vld[1]), .done_o(dn[1]));
  cwpe_gen #(.P(4), .W(3)) u_odd (.clk_i(clk), .rst_ni(rst_n), .start_i(start),
                  .enable_i(enable), .vec_o(v2), .valid_o(vld[2]), .done_o(dn[2]));
  cwpe_gen #(.P(4), .W(3), .EVEN_PARITY(1'b1)) u_even (.clk_i(clk), .rst_ni(rst_n),
                  .start_i(start), .enable_i(enable), .vec_o(v3), .valid_o(vld[3]), .done_o(dn[3]));

  assign vw[0] = {3'b0, v0};
  assign vw[1] = {5'b0, v1};
  assign vw[2] = {4'b0, v2};
  assign vw[3] = {4'b0, v3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full run on DUT idx; vectors in weight order, descending value inside a weight
  task automatic run_set(input int idx, input int p, input int mask, input string req,
                         input int pause_at);
    int exp_v [256];
    int seen  [256];
    int n_exp = 0, got = 0, last_v = 0, pause_left = 0, gap = 0;
    bit done_seen = 0, paused = 0, order_ok = 1, dup_ok = 1;
    for (int k = 0; k <= p; k++)
      if ((mask >> k) & 1)
        for (int v = (1 << p) - 1; v >= 0; v--)
          if (ones(v) == k) begin exp_v[n_exp] = v; n_exp++; end
    for (int i = 0; i < 256; i++) seen[i] = 0;
    pulse_start();
    for (int cyc = 0; cyc < 600 && !done_seen; cyc++) begin
      @(negedge clk);
      if (vld[idx]) begin
        if (got < n_exp && int'(vw[idx]) != exp_v[got]) begin
          order_ok = 0;
          check(0, {req, " R5 order"}, int'(vw[idx]), exp_v[got]);
        end
        if (seen[vw[idx]] != 0) dup_ok = 0;
        seen[vw[idx]]++;
        last_v = int'(vw[idx]);
        got++;
        gap = 0;
      end else begin
        gap++;
        if (dn[idx]) begin
          done_seen = 1;
          check(gap == 1, "R7 done one cycle after last", gap, 1);
          check(int'(vw[idx]) == last_v, "R7 hold at done", int'(vw[idx]), last_v);
        end
      end
      if (paused && pause_left > 0) begin
        check(!vld[idx] && int'(vw[idx]) == last_v, "R6 hold while disabled",
              int'(vw[idx]), last_v);
      end
      // drive enable for the next edge
      if (pause_at > 0 && !paused && got == pause_at) begin
        paused = 1; pause_left = 3; enable = 1'b0;
      end else if (pause_left > 0) begin
        pause_left--;
        enable = (pause_left == 0);
      end
    end
    enable = 1'b1;
    check(done_seen, {req, " R7 done seen"}, done_seen, 1);
    check(got == n_exp, {req, " vector count"}, got, n_exp);
    check(order_ok, {req, " R5 sequence"}, order_ok, 1);
    check(dup_ok, {req, " each vector once"}, dup_ok, 1);
    @(negedge clk);
    check(!dn[idx] && !vld[idx], "R7 done single cycle", dn[idx], 0);
    check(int'(vw[idx]) == last_v, "R7 vector holds after done", int'(vw[idx]), last_v);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++)
      check(!vld[i] && !dn[i] && vw[i] == 8'd0, "R1 reset state", int'(vw[i]), 0);
  endtask

  task automatic t_all();      run_set(1, 3, 'hF, "R2", 0);        endtask
  task automatic t_odd();      run_set(2, 4, 'b01010, "R3 odd", 0); endtask
  task automatic t_even();     run_set(3, 4, 'b10101, "R3 even", 0); endtask
  task automatic t_mask();     run_set(0, 5, 'b001010, "R4", 0);   endtask
  task automatic t_pause();    run_set(0, 5, 'b001010, "R6 pause", 4); endtask

  // R3: the eight odd-parity vectors of p=4 listed explicitly
  task automatic t_odd_list();
    int lst [8] = '{8, 4, 2, 1, 14, 13, 11, 7};
    int n = 0;
    pulse_start();
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (vld[2]) begin
        if (n < 8) check(int'(vw[2]) == lst[n], "R3 listed vector", int'(vw[2]), lst[n]);
        n++;
      end
    end
    check(n == 8, "R3 odd set size", n, 8);
  endtask

  // R8: restart mid-run, first vector again
  task automatic t_restart();
    pulse_start();
    repeat (4) @(negedge clk);
    check(vld[0] && v0 != 5'b10000, "R8 mid-run reached", int'(v0), 0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!vld[0] && !dn[0], "R8 start clears valid", vld[0], 0);
    @(negedge clk);
    check(vld[0] && v0 == 5'b10000, "R8 restart first vector", int'(v0), 16);
    run_set(0, 5, 'b001010, "R8 rerun", 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_all();
    t_odd();
    t_even();
    t_odd_list();
    t_mask();
    t_pause();
    t_restart();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule